// File: doc/BRIEF.md
# Byte-wide SPI Master Controller

This block is a serial peripheral interface master that swaps one byte with an attached slave per transfer. The byte written by software goes out on `mosi` while the slave's byte is gathered from `miso` at the same time. Software chooses the serial clock idle level, which of two clock-phase formats is used, and whether bits travel least or most significant first. A programmable divider sets the serial clock rate. An optional guard watches a sense input for another master driving the shared select line low.

Software programs the control and divider registers while the block is idle. Writing a byte to the data register then starts the exchange. The outgoing select `sel_n` falls, sixteen clock edges move the eight bits, and `sel_n` rises again. Only then does the received byte become readable, and the completion flag is set. Reading the status register and then the data register clears that flag.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset, `sel_n` is 1, `sck` is 0 and `mosi` is 0, and every register address (0 received data, 1 control, 2 divider, 3 status) reads 0.
- R2: A write to address 0 while idle and without a recorded fault starts a transfer. `sel_n` goes low for exactly 16 `sck` edges. The slave receives the written byte, and the received-data register afterwards holds the byte the slave sent.
- R3: Control bit 0 sets the `sck` level whenever `sel_n` is high. Control bit 1 picks the phase. With 0, `miso` is captured on odd edges, and the first `mosi` bit is valid as soon as `sel_n` falls. With 1, `mosi` changes on odd edges and `miso` is captured on even edges.
- R4: With divider value D at address 2, the first `sck` edge comes D+1 clocks after `sel_n` falls. Every later edge follows the previous one by D+1 clocks, and `sel_n` rises D+1 clocks after the 16th edge.
- R5: Control bit 2 set sends and assembles bits least significant first. Cleared, it sends and assembles them most significant first.
- R6: The received-data register keeps its old value during a transfer. It changes only in the cycle `sel_n` rises at the end of a completed transfer.
- R7: Status bit 0 (done) is set in the cycle `sel_n` rises after a completed transfer. Status bit 1 (busy) is 1 while a transfer is in progress.
- R8: Reading status while done is 1, followed later by a read of address 0, clears done. A read of address 0 without that prior status read leaves done set.
- R9: Writes to addresses 0, 1 and 2 during a transfer have no effect: the transfer, the control value and the divider value are unchanged, and no second transfer follows.
- R10: With control bit 3 set, a low `sel_sense_n` sets status bit 2 (fault) and aborts any transfer. In the next cycle `sel_n` is 1 and `sck` is at its idle level, and done is not set. While fault is 1, data writes start nothing. A control write clears fault. With bit 3 clear, `sel_sense_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 data, 1 control, 2 divider |
| wr_data | input | DATA_W | Write value |
| rd_en | input | 1 | Register read strobe (drives the flag-clear sequence) |
| rd_sel | input | 2 | Read address: 0 received data, 1 control, 2 divider, 3 status |
| rd_data | output | DATA_W | Read value for `rd_sel` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| sel_n | output | 1 | Active-low slave select |
| sel_sense_n | input | 1 | Sensed level of the shared select line, for fault detection |

## Verification
A wrong edge counter shows up at the end of the transfer. The edge count seen by the slave model is off, or `sel_n` is released early or late, so the fault appears within one transfer. A divider or baud counter fault changes the measured clock spacing from the first edge onward. A shift or phase fault corrupts the bytes on both sides, and that is caught when the transfer completes and the registers are read back. A fault in the done, armed or fault flags appears at the next status read, a few cycles after the stimulus.

// File: rtl/spi_mst_pkg.sv
`timescale 1ns/1ps
package spi_mst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_TRAIL = 2'd2
    } spi_state_e;

    // cpol sits at bit 0, cpha at 1, lsb_first at 2, fault_en at 3
    typedef struct packed {
        logic fault_en;
        logic lsb_first;
        logic cpha;
        logic cpol;
    } spi_cfg_t;

    localparam int CFG_W = $bits(spi_cfg_t);

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DIV  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/spi_baud_gen.sv
`timescale 1ns/1ps
module spi_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == div) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_reg.sv
`timescale 1ns/1ps
module spi_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         lsb_first,
    input  logic         shift_in,
    output logic [W-1:0] q,
    output logic         out_bit
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (load) begin
            q_d = load_val;
        end else if (shift) begin
            if (lsb_first) q_d = {shift_in, q_q[W-1:1]};
            else           q_d = {q_q[W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q       = q_q;
    assign out_bit = lsb_first ? q_q[0] : q_q[W-1];
endmodule

// File: rtl/spi_master_ctl.sv
`timescale 1ns/1ps
module spi_master_ctl
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              sel_n,
    input  logic              sel_sense_n
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int EDGE_W = $clog2(EDGES + 1);

    typedef struct packed {
        spi_state_e          st;
        logic [EDGE_W-1:0]   edges;
        logic                sck;
        logic                ss_n;
        logic                miso_l;
        spi_cfg_t            cfg;
        logic [DIV_W-1:0]    div;
        logic [DATA_W-1:0]   rx;
        logic                done;
        logic                armed;
        logic                fault;
    } ctl_regs_t;

    ctl_regs_t         r_d, r_q;
    logic              tick, run;
    logic              shf_load, shf_shift, shf_out;
    logic [DATA_W-1:0] shf_q;
    logic [EDGE_W-1:0] edge_n;
    logic              samp_edge, fault_hit;

    // signals brought out for the bound checker
    logic              cfg_cpol, cfg_fault_en, done_flag;
    logic [DATA_W-1:0] rx_hold;

    assign run = (r_q.st != ST_IDLE);

    spi_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (r_q.div),
        .tick  (tick)
    );

    spi_shift_reg #(.W(DATA_W)) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shf_load),
        .load_val  (wr_data),
        .shift     (shf_shift),
        .lsb_first (r_q.cfg.lsb_first),
        .shift_in  (r_q.miso_l),
        .q         (shf_q),
        .out_bit   (shf_out)
    );

    always_comb begin
        r_d       = r_q;
        shf_load  = 1'b0;
        shf_shift = 1'b0;
        edge_n    = r_q.edges + EDGE_W'(1);
        // odd edges capture in phase 0, even edges in phase 1
        samp_edge = edge_n[0] ^ r_q.cfg.cpha;
        fault_hit = r_q.cfg.fault_en && !sel_sense_n;

        if (rd_en && rd_sel == SEL_STAT && r_q.done) r_d.armed = 1'b1;
        if (rd_en && rd_sel == SEL_DATA && r_q.armed) begin
            r_d.done  = 1'b0;
            r_d.armed = 1'b0;
        end

        if (fault_hit) begin
            r_d.fault = 1'b1;
            r_d.st    = ST_IDLE;
            r_d.ss_n  = 1'b1;
            r_d.sck   = r_q.cfg.cpol;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (wr_en) begin
                        case (wr_sel)
                            SEL_DATA: begin
                                if (!r_q.fault) begin
                                    shf_load  = 1'b1;
                                    r_d.st    = ST_XFER;
                                    r_d.ss_n  = 1'b0;
                                    r_d.edges = '0;
                                end
                            end
                            SEL_CTRL: begin
                                r_d.cfg   = wr_data[CFG_W-1:0];
                                r_d.fault = 1'b0;
                            end
                            SEL_DIV: r_d.div = wr_data[DIV_W-1:0];
                            default: ;
                        endcase
                    end
                    r_d.sck = r_d.cfg.cpol;
                end
                ST_XFER: begin
                    if (tick) begin
                        r_d.sck   = ~r_q.sck;
                        r_d.edges = edge_n;
                        if (samp_edge) begin
                            r_d.miso_l = miso;
                        end else if (!(r_q.cfg.cpha && edge_n == EDGE_W'(1))) begin
                            shf_shift = 1'b1;
                        end
                        if (edge_n == EDGE_W'(EDGES)) r_d.st = ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (r_q.cfg.cpha) begin
                            // phase 1 still owes the last shift
                            shf_shift = 1'b1;
                            if (r_q.cfg.lsb_first)
                                r_d.rx = {r_q.miso_l, shf_q[DATA_W-1:1]};
                            else
                                r_d.rx = {shf_q[DATA_W-2:0], r_q.miso_l};
                        end else begin
                            r_d.rx = shf_q;
                        end
                        r_d.st   = ST_IDLE;
                        r_d.ss_n = 1'b1;
                        r_d.done = 1'b1;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ss_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_DATA: rd_data = r_q.rx;
            SEL_CTRL: rd_data = DATA_W'(r_q.cfg);
            SEL_DIV:  rd_data = DATA_W'(r_q.div);
            default:  rd_data = DATA_W'({r_q.fault, run, r_q.done});
        endcase
    end

    assign sck          = r_q.sck;
    assign sel_n        = r_q.ss_n;
    assign mosi         = shf_out;
    assign cfg_cpol     = r_q.cfg.cpol;
    assign cfg_fault_en = r_q.cfg.fault_en;
    assign done_flag    = r_q.done;
    assign rx_hold      = r_q.rx;
endmodule

// File: rtl/spi_master_ctl_chk.sv
`timescale 1ns/1ps
module spi_master_ctl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              sel_n,
    input logic              sel_sense_n,
    input logic              cpol,
    input logic              fault_en,
    input logic              done,
    input logic [DATA_W-1:0] rx
);
    // R3
    sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (sck == cpol));

    // R7
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $rose(sel_n));

    // R6
    rx_update_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx) |-> $rose(sel_n));

    // R10
    fault_releases_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_en && !sel_sense_n) |=> sel_n);
endmodule

bind spi_master_ctl spi_master_ctl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .sel_n       (sel_n),
    .sel_sense_n (sel_sense_n),
    .cpol        (cfg_cpol),
    .fault_en    (cfg_fault_en),
    .done        (done_flag),
    .rx          (rx_hold)
);

// File: tb/spi_master_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_master_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       sck, mosi, sel_n;
    logic       miso = 1'b0, sel_sense_n = 1'b1;

    always #4 clk = ~clk;

    spi_master_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .sck(sck), .mosi(mosi),
        .miso(miso), .sel_n(sel_n), .sel_sense_n(sel_sense_n)
    );

    int unsigned n_cmp = 0, n_bad = 0, cyc = 0;
    always @(negedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // slave model
    logic [7:0]  s_tx = '0, s_rx = '0;
    int          s_edges = 0;
    int unsigned t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
    bit          gap_bad = 0;
    logic        m_cpol = 0, m_cpha = 0, m_lsb = 0;
    int          m_div = 0;

    function automatic logic sbit(int k);
        return m_lsb ? s_tx[k] : s_tx[7-k];
    endfunction

    always @(negedge sel_n) begin
        s_edges = 0;
        s_rx    = '0;
        gap_bad = 0;
        t_fall  = cyc;
        if (!m_cpha) miso = sbit(0);
    end

    always @(posedge sel_n) t_rise = cyc;

    always @(sck) begin : slave_edge
        int idx, di;
        if (sel_n === 1'b0) begin
            s_edges++;
            if (s_edges == 1) t_first = cyc;
            else if (cyc - t_last != m_div + 1) gap_bad = 1;
            t_last = cyc;
            idx = (s_edges - 1) / 2;
            if ((s_edges % 2 == 1) ^ m_cpha) begin
                if (idx < 8) s_rx[m_lsb ? idx : 7 - idx] = mosi;
            end else begin
                di = m_cpha ? idx : s_edges / 2;
                if (di < 8) miso = sbit(di);
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_sel = sel;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic setup(input logic cpol, input logic cpha, input logic lsb, input logic fen, input int div);
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_div = div;
        wr(2'd1, {4'b0, fen, lsb, cpha, cpol});
        wr(2'd2, 8'(div));
    endtask

    task automatic xfer_check(input logic [7:0] mtx, input logic [7:0] stx);
        logic [7:0] v;
        s_tx = stx;
        wr(2'd0, mtx);
        chk("R7", {31'b0, sel_n}, 0, "select low during transfer");
        @(posedge sel_n); @(negedge clk);
        chk("R2", s_edges, 16, "sck edge count");
        chk("R5", s_rx, mtx, "byte seen by slave");
        chk("R4", t_first - t_fall, m_div + 1, "select to first edge");
        chk("R4", {31'b0, gap_bad}, 0, "edge spacing");
        chk("R4", t_rise - t_last, m_div + 1, "last edge to release");
        chk("R3", {31'b0, sck}, {31'b0, m_cpol}, "idle sck level");
        rd(2'd3, v);
        chk("R7", v, 8'h01, "status after transfer");
        rd(2'd0, v);
        chk("R2", v, stx, "received byte");
        rd(2'd3, v);
        chk("R8", v, 8'h00, "done cleared by status-then-data read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {29'b0, sel_n, sck, mosi}, 32'h4, "sel_n/sck/mosi after reset");
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", v, 8'h00, "register after reset");
        end

        // R2 R3 R4 R5 sweep over modes, orders, dividers and patterns
        for (int md = 0; md < 4; md++)
            for (int lb = 0; lb < 2; lb++)
                for (int dv = 0; dv < 3; dv++) begin
                    setup(md[1], md[0], lb[0], 1'b0, (dv == 2) ? 3 : dv);
                    for (int p = 0; p < 3; p++) begin
                        logic [7:0] mt;
                        mt = 8'(p * 37 + md * 11 + lb * 5 + dv + 1);
                        xfer_check(mt, ~mt ^ 8'(p * 19 + 3));
                    end
                end

        // R6 old data readable mid-transfer
        setup(1'b0, 1'b0, 1'b0, 1'b0, 3);
        xfer_check(8'h12, 8'h5A);
        s_tx = 8'hC3;
        wr(2'd0, 8'h34);
        repeat (20) @(negedge clk);
        rd(2'd0, v);
        chk("R6", v, 8'h5A, "rx during transfer keeps old byte");
        rd(2'd3, v);
        chk("R7", v, 8'h02, "busy during transfer");
        @(posedge sel_n); @(negedge clk);
        rd(2'd0, v);
        chk("R6", v, 8'hC3, "rx after completion");

        // R8 data read alone leaves done set
        rd(2'd3, v); rd(2'd0, v);
        xfer_check(8'h0F, 8'hF0);
        s_tx = 8'h81;
        wr(2'd0, 8'h7E);
        @(posedge sel_n); @(negedge clk);
        rd(2'd0, v);
        rd(2'd3, v);
        chk("R8", v, 8'h01, "done kept after bare data read");
        rd(2'd0, v);
        rd(2'd3, v);
        chk("R8", v, 8'h00, "done cleared after status then data");

        // R9 writes during transfer ignored
        setup(1'b0, 1'b1, 1'b0, 1'b0, 3);
        s_tx = 8'h69;
        wr(2'd0, 8'h96);
        repeat (6) @(negedge clk);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h00);
        @(posedge sel_n); @(negedge clk);
        chk("R9", s_rx, 8'h96, "slave byte unaffected");
        chk("R9", {31'b0, gap_bad}, 0, "divider unaffected");
        rd(2'd1, v); chk("R9", v, 8'h02, "control unaffected");
        rd(2'd2, v); chk("R9", v, 8'h03, "divider readback");
        rd(2'd3, v); rd(2'd0, v);
        chk("R9", v, 8'h69, "received byte");
        repeat (40) @(negedge clk);
        chk("R9", {31'b0, sel_n}, 1, "no second transfer");

        // R10 mode fault
        setup(1'b0, 1'b0, 1'b0, 1'b1, 3);
        s_tx = 8'h44;
        wr(2'd0, 8'hAB);
        repeat (12) @(negedge clk);
        sel_sense_n = 1'b0;
        @(negedge clk);
        chk("R10", {30'b0, sel_n, sck}, 32'h2, "abort releases select, sck idle");
        sel_sense_n = 1'b1;
        rd(2'd3, v);
        chk("R10", v, 8'h04, "fault set, not busy, not done");
        wr(2'd0, 8'h11);
        repeat (4) @(negedge clk);
        chk("R10", {31'b0, sel_n}, 1, "data write ignored while fault");
        wr(2'd1, 8'h08);
        rd(2'd3, v);
        chk("R10", v, 8'h00, "control write clears fault");
        xfer_check(8'h3D, 8'hD3);

        // R10 detection disabled: sense has no effect
        setup(1'b1, 1'b1, 1'b1, 1'b0, 1);
        s_tx = 8'h2C;
        wr(2'd0, 8'hE1);
        repeat (5) @(negedge clk);
        sel_sense_n = 1'b0;
        @(posedge sel_n); @(negedge clk);
        sel_sense_n = 1'b1;
        chk("R10", s_edges, 16, "full transfer with detection off");
        chk("R10", s_rx, 8'hE1, "slave byte with detection off");
        rd(2'd3, v);
        chk("R10", v, 8'h01, "no fault with detection off");
        rd(2'd0, v);
        chk("R10", v, 8'h2C, "received byte with detection off");

        summary();
        $finish;
    end
endmodule